// File: doc/BRIEF.md
# Twelve-Bit Pipelined Floating-Point Multiplier

This block multiplies two numbers held in a compact 12-bit floating-point word and returns their product in the same word. The top bit is the sign, the next four bits are an exponent stored with an offset of 8, and the low seven bits are a fraction with an implied leading one. An exponent field of zero marks a zero operand. The block handles neither denormal operands nor not-a-number codes.

The work is split over three register stages, and a new operand pair may enter on every clock. The first stage forms the sign, the tentative exponent and the 16-bit significand product. The second stage normalizes the product and extracts the guard and sticky bits. The third stage rounds to nearest-even, applies the final exponent adjustment, classifies the result and packs it. An input valid bit travels alongside the data and arrives as the output valid bit. Three flags mark a result that is zero because an operand was zero, a result that saturated on overflow, and a result that was flushed to zero on underflow.

The third stage sorts each result into one of four classes through an enumerated type: normal, zero operand, overflow and underflow. The pack logic selects the output word from that class through a unique case. The block contains no other sequencing.

Top module: `fpm_mul12`

## Requirements
- R1: For non-zero operands with an in-range result, the output exponent field equals the sum of the operand exponent fields minus 8, adjusted by normalization and rounding. The output fraction is the rounded product of the significands (1.fraction), truncated to seven bits after the implied one.
- R2: The output sign bit (bit 11) is the XOR of the operand sign bits. This holds for every result class.
- R3: When the significand product is below 2, no normalization shift is made and the tentative exponent is kept.
- R4: When the significand product is 2 or above, the product is shifted right by one bit and the exponent rises by one.
- R5: Rounding is to nearest, with ties to even. A discarded part above one half rounds up. A discarded part of exactly one half rounds up only when the kept fraction is odd.
- R6: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one more.
- R7: When either operand has exponent field 0, the output is a zero word (bits 10:0 clear) carrying the XOR sign, and zero_flag is set.
- R8: When the final biased exponent exceeds 15, the output saturates to exponent field 15 and fraction 7'h7F with the XOR sign, and ovf_flag is set.
- R9: When the final biased exponent is below 1, the output is flushed to a zero word with the XOR sign, and unf_flag is set.
- R10: A result appears on the third rising clock edge after its operands are sampled with in_valid high. One result can be produced per cycle. out_valid is high exactly for those results, and it is low after reset.
- R11: At most one flag is high at a time, and every flag is low while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| a_word | input | 12 | First operand |
| b_word | input | 12 | Second operand |
| out_valid | output | 1 | Result is present this cycle |
| prod_word | output | 12 | Packed product |
| zero_flag | output | 1 | Result is zero because an operand was zero |
| ovf_flag | output | 1 | Result saturated on exponent overflow |
| unf_flag | output | 1 | Result flushed to zero on exponent underflow |

## Verification
The assertions assume that in_valid and both operand words carry known values on every clock edge after reset. They also assume that an operand with exponent field zero is meant as zero, whatever its fraction holds. The stimulus drives every input at the falling edge, keeps in_valid low during reset, and marks zero operands only through a zero exponent field. Because the block has no subnormal or not-a-number codes, every 12-bit pattern is a legal operand. The random part of the stimulus therefore covers the whole word.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Classification of a rounded product before packing.
    typedef enum logic [1:0] {
        RES_NORMAL = 2'd0,
        RES_ZERO   = 2'd1,
        RES_OVF    = 2'd2,
        RES_UNF    = 2'd3
    } fpm_class_e;

endpackage

// File: rtl/fpm_stage_mul.sv
// Stage 1: sign, zero detection, tentative exponent and significand product.
module fpm_stage_mul #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [EXP_W+FRAC_W:0]          a_word,
    input  logic [EXP_W+FRAC_W:0]          b_word,
    output logic                           s1_valid,
    output logic                           s1_sign,
    output logic                           s1_zero,
    output logic signed [EXP_W+2:0]        s1_exp,
    output logic [2*(FRAC_W+1)-1:0]        s1_prod
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int XE_W   = EXP_W + 3;
    localparam logic signed [XE_W-1:0] BIAS = XE_W'(2 ** (EXP_W - 1));

    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [SIG_W-1:0]  sig_a, sig_b;
    logic              sign_n, zero_n;
    logic signed [XE_W-1:0] exp_n;
    logic [PROD_W-1:0] prod_n;

    always_comb begin
        exp_a  = a_word[WORD_W-2 -: EXP_W];
        exp_b  = b_word[WORD_W-2 -: EXP_W];
        sig_a  = {1'b1, a_word[FRAC_W-1:0]};
        sig_b  = {1'b1, b_word[FRAC_W-1:0]};
        sign_n = a_word[WORD_W-1] ^ b_word[WORD_W-1];
        zero_n = (exp_a == '0) || (exp_b == '0);
        exp_n  = $signed({3'b000, exp_a}) + $signed({3'b000, exp_b}) - BIAS;
        prod_n = PROD_W'(sig_a) * PROD_W'(sig_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_zero  <= 1'b0;
            s1_exp   <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= sign_n;
            s1_zero  <= zero_n;
            s1_exp   <= exp_n;
            s1_prod  <= prod_n;
        end
    end
endmodule

// File: rtl/fpm_stage_norm.sv
// Stage 2: one-bit normalization, guard and sticky extraction.
module fpm_stage_norm #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s1_valid,
    input  logic                       s1_sign,
    input  logic                       s1_zero,
    input  logic signed [EXP_W+2:0]    s1_exp,
    input  logic [2*(FRAC_W+1)-1:0]    s1_prod,
    output logic                       s2_valid,
    output logic                       s2_sign,
    output logic                       s2_zero,
    output logic signed [EXP_W+2:0]    s2_exp,
    output logic [FRAC_W-1:0]          s2_frac,
    output logic                       s2_guard,
    output logic                       s2_sticky
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XE_W   = EXP_W + 3;
    localparam int LOW_W  = PROD_W - SIG_W;  // bits below the kept significand when shifted

    logic                    wide;
    logic [FRAC_W-1:0]       frac_n;
    logic                    guard_n, sticky_n;
    logic signed [XE_W-1:0]  exp_n;

    always_comb begin
        wide = s1_prod[PROD_W-1];
        if (wide) begin
            frac_n   = s1_prod[PROD_W-2 -: FRAC_W];
            guard_n  = s1_prod[LOW_W-1];
            sticky_n = |s1_prod[LOW_W-2:0];
        end else begin
            frac_n   = s1_prod[PROD_W-3 -: FRAC_W];
            guard_n  = s1_prod[LOW_W-2];
            sticky_n = |s1_prod[LOW_W-3:0];
        end
        exp_n = s1_exp + $signed({{(XE_W-1){1'b0}}, wide});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_sign   <= 1'b0;
            s2_zero   <= 1'b0;
            s2_exp    <= '0;
            s2_frac   <= '0;
            s2_guard  <= 1'b0;
            s2_sticky <= 1'b0;
        end else begin
            s2_valid  <= s1_valid;
            s2_sign   <= s1_sign;
            s2_zero   <= s1_zero;
            s2_exp    <= exp_n;
            s2_frac   <= frac_n;
            s2_guard  <= guard_n;
            s2_sticky <= sticky_n;
        end
    end
endmodule

// File: rtl/fpm_stage_pack.sv
// Stage 3: round to nearest-even, exponent adjust, classify and pack.
module fpm_stage_pack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s2_valid,
    input  logic                        s2_sign,
    input  logic                        s2_zero,
    input  logic signed [EXP_W+2:0]     s2_exp,
    input  logic [FRAC_W-1:0]           s2_frac,
    input  logic                        s2_guard,
    input  logic                        s2_sticky,
    output logic                        out_valid,
    output logic [EXP_W+FRAC_W:0]       prod_word,
    output logic                        zero_flag,
    output logic                        ovf_flag,
    output logic                        unf_flag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int XE_W   = EXP_W + 3;
    localparam logic signed [XE_W-1:0] EXP_TOP = XE_W'(2 ** EXP_W - 1);
    localparam logic signed [XE_W-1:0] EXP_LOW = XE_W'(1);

    logic                   round_up;
    logic [FRAC_W:0]        frac_sum;
    logic signed [XE_W-1:0] exp_fin;
    fpm_class_e             res_class;
    logic [WORD_W-1:0]      word_n;
    logic                   zf_n, of_n, uf_n;

    always_comb begin
        round_up = s2_guard & (s2_sticky | s2_frac[0]);
        frac_sum = {1'b0, s2_frac} + {{FRAC_W{1'b0}}, round_up};
        exp_fin  = s2_exp + $signed({{(XE_W-1){1'b0}}, frac_sum[FRAC_W]});

        if (s2_zero)                res_class = RES_ZERO;
        else if (exp_fin > EXP_TOP) res_class = RES_OVF;
        else if (exp_fin < EXP_LOW) res_class = RES_UNF;
        else                        res_class = RES_NORMAL;
    end

    always_comb begin
        zf_n = 1'b0;
        of_n = 1'b0;
        uf_n = 1'b0;
        unique case (res_class)
            RES_NORMAL: word_n = {s2_sign, exp_fin[EXP_W-1:0], frac_sum[FRAC_W-1:0]};
            RES_ZERO: begin
                word_n = {s2_sign, {(WORD_W-1){1'b0}}};
                zf_n   = 1'b1;
            end
            RES_OVF: begin
                word_n = {s2_sign, {(WORD_W-1){1'b1}}};
                of_n   = 1'b1;
            end
            RES_UNF: begin
                word_n = {s2_sign, {(WORD_W-1){1'b0}}};
                uf_n   = 1'b1;
            end
            default: word_n = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            prod_word <= '0;
            zero_flag <= 1'b0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            prod_word <= word_n;
            zero_flag <= zf_n & s2_valid;
            ovf_flag  <= of_n & s2_valid;
            unf_flag  <= uf_n & s2_valid;
        end
    end
endmodule

// File: rtl/fpm_mul12.sv
// Three-stage small-format floating-point multiplier.
module fpm_mul12 #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   a_word,
    input  logic [EXP_W+FRAC_W:0]   b_word,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   prod_word,
    output logic                    zero_flag,
    output logic                    ovf_flag,
    output logic                    unf_flag
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XE_W   = EXP_W + 3;

    logic                   s1_valid, s1_sign, s1_zero;
    logic signed [XE_W-1:0] s1_exp;
    logic [PROD_W-1:0]      s1_prod;

    logic                   s2_valid, s2_sign, s2_zero, s2_guard, s2_sticky;
    logic signed [XE_W-1:0] s2_exp;
    logic [FRAC_W-1:0]      s2_frac;

    fpm_stage_mul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .a_word   (a_word),
        .b_word   (b_word),
        .s1_valid (s1_valid),
        .s1_sign  (s1_sign),
        .s1_zero  (s1_zero),
        .s1_exp   (s1_exp),
        .s1_prod  (s1_prod)
    );

    fpm_stage_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_sign   (s1_sign),
        .s1_zero   (s1_zero),
        .s1_exp    (s1_exp),
        .s1_prod   (s1_prod),
        .s2_valid  (s2_valid),
        .s2_sign   (s2_sign),
        .s2_zero   (s2_zero),
        .s2_exp    (s2_exp),
        .s2_frac   (s2_frac),
        .s2_guard  (s2_guard),
        .s2_sticky (s2_sticky)
    );

    fpm_stage_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .s2_valid  (s2_valid),
        .s2_sign   (s2_sign),
        .s2_zero   (s2_zero),
        .s2_exp    (s2_exp),
        .s2_frac   (s2_frac),
        .s2_guard  (s2_guard),
        .s2_sticky (s2_sticky),
        .out_valid (out_valid),
        .prod_word (prod_word),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );
endmodule

// File: rtl/fpm_mul12_chk.sv
// Port-level checker for the multiplier, attached by bind.
module fpm_mul12_chk #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] a_word,
    input logic [EXP_W+FRAC_W:0] b_word,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] prod_word,
    input logic                  zero_flag,
    input logic                  ovf_flag,
    input logic                  unf_flag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [2:0] vhist, shist, zhist;
    logic       zin;

    assign zin = (a_word[WORD_W-2 -: EXP_W] == '0) || (b_word[WORD_W-2 -: EXP_W] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist <= '0;
            shist <= '0;
            zhist <= '0;
        end else begin
            vhist <= {vhist[1:0], in_valid};
            shist <= {shist[1:0], a_word[WORD_W-1] ^ b_word[WORD_W-1]};
            zhist <= {zhist[1:0], in_valid & zin};
        end
    end

    a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[2]);

    a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> prod_word[WORD_W-1] == shist[2]);

    a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zhist[2]) |-> (zero_flag && prod_word[WORD_W-2:0] == '0));

    a_r8_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> prod_word[WORD_W-2:0] == '1);

    a_r9_unf_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> prod_word[WORD_W-2:0] == '0);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zero_flag, ovf_flag, unf_flag}));

    a_r11_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag || ovf_flag || unf_flag) |-> out_valid);

    a_r1_normal_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !zero_flag && !ovf_flag && !unf_flag) |-> prod_word[WORD_W-2 -: EXP_W] != '0);
endmodule

bind fpm_mul12 fpm_mul12_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_word    (a_word),
    .b_word    (b_word),
    .out_valid (out_valid),
    .prod_word (prod_word),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/fpm_mul12_bench.sv
module fpm_mul12_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] a_word = '0;
    logic [11:0] b_word = '0;
    logic        out_valid;
    logic [11:0] prod_word;
    logic        zero_flag, ovf_flag, unf_flag;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    typedef struct {
        logic [11:0] w;
        logic        z, o, u;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_mul12 u_fpm_mul12 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_word    (a_word),
        .b_word    (b_word),
        .out_valid (out_valid),
        .prod_word (prod_word),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    // Result model written from the requirements: {word, zero, ovf, unf}.
    function automatic logic [14:0] model(input logic [11:0] a, input logic [11:0] b);
        int ea, eb, e, p, m, rem, half;
        logic s;
        s  = a[11] ^ b[11];
        ea = int'(a[10:7]);
        eb = int'(b[10:7]);
        if (ea == 0 || eb == 0) return {s, 11'd0, 3'b100};
        p = (128 + int'(a[6:0])) * (128 + int'(b[6:0]));
        e = ea + eb - 8;
        if (p >= 32768) begin
            e = e + 1; m = p / 256; rem = p % 256; half = 128;
        end else begin
            m = p / 128; rem = p % 128; half = 64;
        end
        if (rem > half || (rem == half && (m % 2) == 1)) m = m + 1;
        if (m == 256) begin m = 128; e = e + 1; end
        if (e > 15) return {s, 4'hF, 7'h7F, 3'b010};
        if (e < 1)  return {s, 11'd0, 3'b001};
        return {s, 4'(e), 7'(m - 128), 3'b000};
    endfunction

    task automatic send(input logic [11:0] a, input logic [11:0] b, input string tag);
        exp_t it;
        logic [14:0] r;
        @(negedge clk);
        in_valid = 1'b1;
        a_word   = a;
        b_word   = b;
        r = model(a, b);
        it.w = r[14:3]; it.z = r[2]; it.o = r[1]; it.u = r[0]; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(input logic ok, input string tag, input logic [14:0] act, input logic [14:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each produced result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected out_valid", {prod_word, zero_flag, ovf_flag, unf_flag}, 15'd0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check({prod_word, zero_flag, ovf_flag, unf_flag} == {it.w, it.z, it.o, it.u},
                          it.tag, {prod_word, zero_flag, ovf_flag, unf_flag}, {it.w, it.z, it.o, it.u});
                end
            end else if (zero_flag || ovf_flag || unf_flag) begin
                check(1'b0, "R11 flag without valid", {prod_word, zero_flag, ovf_flag, unf_flag}, 15'd0);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] st;
        st = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // Reset state: nothing valid, word and flags clear (R10, R11).
        check(out_valid == 1'b0 && prod_word == '0, "R10 reset state",
              {prod_word, zero_flag, ovf_flag, unf_flag, out_valid}, 15'd0);
        check(!zero_flag && !ovf_flag && !unf_flag, "R11 reset flags",
              {12'd0, zero_flag, ovf_flag, unf_flag}, 15'd0);
        @(negedge clk);
        rst_n = 1'b1;

        send({1'b0, 4'd8, 7'd0},   {1'b0, 4'd8, 7'd0},   "R1 one times one");
        send({1'b0, 4'd9, 7'd32},  {1'b0, 4'd6, 7'd16},  "R3 no shift product");
        send({1'b1, 4'd8, 7'd64},  {1'b0, 4'd7, 7'd0},   "R2 negative times positive");
        send({1'b1, 4'd9, 7'd5},   {1'b1, 4'd9, 7'd9},   "R2 negative times negative");
        send({1'b0, 4'd8, 7'd64},  {1'b0, 4'd8, 7'd64},  "R4 product above two");
        send({1'b0, 4'd8, 7'd64},  {1'b0, 4'd8, 7'd1},   "R5 tie odd rounds up");
        send({1'b0, 4'd8, 7'd64},  {1'b0, 4'd8, 7'd3},   "R5 tie even stays");
        send({1'b0, 4'd8, 7'd53},  {1'b0, 4'd8, 7'd53},  "R6 rounding carry");
        send({1'b1, 4'd0, 7'd99},  {1'b0, 4'd9, 7'd1},   "R7 zero operand a");
        send({1'b0, 4'd12, 7'd5},  {1'b1, 4'd0, 7'd0},   "R7 zero operand b");
        send({1'b0, 4'd15, 7'd0},  {1'b1, 4'd15, 7'd0},  "R8 overflow");
        send({1'b0, 4'd12, 7'd0},  {1'b0, 4'd11, 7'd0},  "R8 boundary exp 15 kept");
        send({1'b0, 4'd12, 7'd64}, {1'b0, 4'd11, 7'd64}, "R8 overflow from shift");
        send({1'b1, 4'd1, 7'd0},   {1'b0, 4'd1, 7'd0},   "R9 underflow");
        send({1'b0, 4'd4, 7'd0},   {1'b0, 4'd5, 7'd0},   "R9 boundary exp 1 kept");
        send({1'b0, 4'd4, 7'd64},  {1'b0, 4'd4, 7'd64},  "R9 shift rescues underflow");
        send({1'b0, 4'd4, 7'd0},   {1'b0, 4'd4, 7'd0},   "R9 exp 0 underflow");
        idle(2);
        send({1'b0, 4'd10, 7'd17}, {1'b1, 4'd7, 7'd100}, "R10 after bubble");
        idle(1);

        for (int k = 0; k < 300; k++) begin
            logic [11:0] ra, rb;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            ra = st[11:0];
            rb = st[27:16];
            send(ra, rb, "R1 random stream");
            if (st[31:29] == 3'b000) idle(1);
        end

        idle(6);
        check(sb_q.size() == 0, "R10 all results delivered",
              15'(sb_q.size()), 15'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule